// File: doc/BRIEF.md
# Composite Video Timing and Colour Generator

This block produces the digital drive bits for a colour composite video output. It runs from a single clock at sixteen times the colour subcarrier (about 57.27 MHz), so every timing decision is a count of clock ticks.

A horizontal state machine walks each scan line through six states: sync tip, breezeway gap, colour burst, back porch, active picture and front porch. The default line is 3640 clocks, which is 227.5 subcarrier cycles. A line counter runs over a 525-line frame made of two interlaced fields of 262.5 lines each. It decodes a vertical phase for each line: vertical sync, vertical blanking or picture.

During picture time the block asks for a new 8-bit colour code every four clocks and registers it. The upper nibble of the code is the luma level. The lower nibble picks one of fifteen delayed copies of the subcarrier square wave, or constant zero for grey. An external resistor network mixes the luma code, the chroma bit, the sync bit and the burst enable into the analog signal.

Top module: `composite_timing_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the counters sit at field 1, line 0, clock 0. In that state `csync_n` is 0 and `burst_en`, `pix_req`, `luma` and `chroma` are all 0.
- R2: Outside vertical sync, `csync_n` is low for the first HSYNC_CLKS clocks of every line and high for the rest of the line.
- R3: `burst_en` is high for BURST_CLKS clocks, starting HSYNC_CLKS+GAP_CLKS clocks into the line, on every line that is not in vertical sync. It is low at all other times.
- R4: On picture lines, `pix_req` pulses on the first active clock and then every PIX_DIV clocks, giving ACTIVE_CLKS/PIX_DIV requests per line. It is never high on other lines or outside the active window.
- R5: The code presented while `pix_req` is high is captured on that clock edge. Its bits [7:4] appear on `luma` from the next cycle until the next capture. Outside the active window of a picture line, `luma` is 0.
- R6: A captured code whose bits [3:0] are 0 holds `chroma` at 0 for that pixel.
- R7: A captured chroma value k from 1 to 15 makes `chroma` equal to the subcarrier delayed by k clocks. The subcarrier is high when the count of clocks since reset, taken modulo 16, is below 8.
- R8: In field 1, `csync_n` is low for the whole of lines 0 to VSYNC_LINES-1.
- R9: Field 2 starts half a line into line MID = (LINES-1)/2. Its vertical sync holds `csync_n` low from that point for VSYNC_LINES line times.
- R10: Vertical blanking covers lines 0 to VBLANK_LINES-1 and lines MID to MID+VBLANK_LINES. On those lines `pix_req`, `luma` and `chroma` stay 0.
- R11: A colour code of 0x00 gives luma 0 with `csync_n` still high, so black is never taken for sync.
- R12: The whole pattern repeats every LINES×LINE_CLKS clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 16× subcarrier |
| rst | input | 1 | Synchronous reset, active high |
| color_code | input | 8 | Pixel code, sampled on clocks where pix_req is high |
| pix_req | output | 1 | Strobe requesting the next pixel code |
| luma | output | 4 | Luma level for the resistor network |
| chroma | output | 1 | Phase-selected subcarrier square wave |
| csync_n | output | 1 | Composite sync, low during sync pulses |
| burst_en | output | 1 | Enable for the weaker colour-burst injection |

## Verification
`csync_n`, `burst_en` and `pix_req` decode the counter registers directly, so they are due in the same cycle as the counter value. A code presented during a request shows on `luma` and `chroma` exactly one clock later and holds for PIX_DIV clocks. The bench keeps its own tick count from the release of reset and derives the line position, the vertical phase and the subcarrier phase from it. It also records the code it drove on each cycle it expects a request, then compares every output at the falling edge against that model. Since all outputs settle after the rising edge, each comparison falls in the cycle the requirement names.

// File: rtl/cvgen_pkg.sv
package cvgen_pkg;

    typedef enum logic [2:0] {
        H_SYNC,
        H_GAP,
        H_BURST,
        H_BACK,
        H_ACTIVE,
        H_FRONT
    } hstate_e;

    typedef enum logic [1:0] {
        V_SYNC,
        V_BLANK,
        V_PICTURE
    } vphase_e;

endpackage

// File: rtl/cv_line_fsm.sv
module cv_line_fsm
    import cvgen_pkg::*;
#(
    parameter int LINE_CLKS   = 3640,
    parameter int HSYNC_CLKS  = 269,
    parameter int GAP_CLKS    = 38,
    parameter int BURST_CLKS  = 144,
    parameter int BACK_CLKS   = 89,
    parameter int ACTIVE_CLKS = 2960,
    parameter int PIX_DIV     = 4,
    parameter int HW          = $clog2(LINE_CLKS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] hcnt,
    output logic          line_end,
    output logic          in_hsync,
    output logic          in_burst,
    output logic          in_active,
    output logic          pix_slot
);

    localparam int DW = (PIX_DIV > 1) ? $clog2(PIX_DIV) : 1;
    localparam int E_SYNC   = HSYNC_CLKS - 1;
    localparam int E_GAP    = HSYNC_CLKS + GAP_CLKS - 1;
    localparam int E_BURST  = E_GAP + BURST_CLKS;
    localparam int E_BACK   = E_BURST + BACK_CLKS;
    localparam int E_ACTIVE = E_BACK + ACTIVE_CLKS;
    localparam logic [HW-1:0] K_SYNC   = HW'(E_SYNC);
    localparam logic [HW-1:0] K_GAP    = HW'(E_GAP);
    localparam logic [HW-1:0] K_BURST  = HW'(E_BURST);
    localparam logic [HW-1:0] K_BACK   = HW'(E_BACK);
    localparam logic [HW-1:0] K_ACTIVE = HW'(E_ACTIVE);
    localparam logic [HW-1:0] K_LAST   = HW'(LINE_CLKS - 1);
    localparam logic [DW-1:0] K_DLAST  = DW'(PIX_DIV - 1);

    hstate_e       state, nstate;
    logic [DW-1:0] pdiv;

    // state register and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= H_SYNC;
            hcnt  <= '0;
            pdiv  <= '0;
        end else begin
            state <= nstate;
            hcnt  <= (hcnt == K_LAST) ? '0 : hcnt + 1'b1;
            if (state == H_ACTIVE && pdiv != K_DLAST)
                pdiv <= pdiv + 1'b1;
            else
                pdiv <= '0;
        end
    end

    // transitions at the last clock of each segment
    always_comb begin
        nstate = state;
        unique case (state)
            H_SYNC:   if (hcnt == K_SYNC)   nstate = H_GAP;
            H_GAP:    if (hcnt == K_GAP)    nstate = H_BURST;
            H_BURST:  if (hcnt == K_BURST)  nstate = H_BACK;
            H_BACK:   if (hcnt == K_BACK)   nstate = H_ACTIVE;
            H_ACTIVE: if (hcnt == K_ACTIVE) nstate = H_FRONT;
            H_FRONT:  if (hcnt == K_LAST)   nstate = H_SYNC;
            default:                        nstate = H_SYNC;
        endcase
    end

    // decoded outputs
    always_comb begin
        line_end  = (hcnt == K_LAST);
        in_hsync  = (state == H_SYNC);
        in_burst  = (state == H_BURST);
        in_active = (state == H_ACTIVE);
        pix_slot  = (state == H_ACTIVE) && (pdiv == '0);
    end

endmodule

// File: rtl/cv_field_seq.sv
module cv_field_seq
    import cvgen_pkg::*;
#(
    parameter int LINE_CLKS    = 3640,
    parameter int LINES        = 525,
    parameter int VSYNC_LINES  = 3,
    parameter int VBLANK_LINES = 20,
    parameter int HW           = $clog2(LINE_CLKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_end,
    input  logic [HW-1:0] hcnt,
    output vphase_e       vphase
);

    localparam int LW  = $clog2(LINES);
    localparam int MID = (LINES - 1) / 2;
    localparam logic [LW-1:0] K_LAST  = LW'(LINES - 1);
    localparam logic [LW-1:0] K_MID   = LW'(MID);
    localparam logic [LW-1:0] K_VS1   = LW'(VSYNC_LINES);
    localparam logic [LW-1:0] K_VS2E  = LW'(MID + VSYNC_LINES);
    localparam logic [LW-1:0] K_VB1   = LW'(VBLANK_LINES);
    localparam logic [LW-1:0] K_VB2E  = LW'(MID + VBLANK_LINES);
    localparam logic [HW-1:0] K_HALF  = HW'(LINE_CLKS / 2);

    logic [LW-1:0] line;
    logic          second_half;
    logic          vs_f1, vs_f2, blank;

    always_ff @(posedge clk) begin
        if (rst)
            line <= '0;
        else if (line_end)
            line <= (line == K_LAST) ? '0 : line + 1'b1;
    end

    always_comb begin
        second_half = (hcnt >= K_HALF);
        vs_f1 = (line < K_VS1);
        vs_f2 = (line == K_MID && second_half)
             || (line > K_MID && line < K_VS2E)
             || (line == K_VS2E && !second_half);
        blank = (line < K_VB1) || (line >= K_MID && line <= K_VB2E);
        if (vs_f1 || vs_f2)
            vphase = V_SYNC;
        else if (blank)
            vphase = V_BLANK;
        else
            vphase = V_PICTURE;
    end

endmodule

// File: rtl/cv_pixel_latch.sv
module cv_pixel_latch #(
    parameter int LUMA_W   = 4,
    parameter int CHROMA_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic                       show_next,
    input  logic [LUMA_W+CHROMA_W-1:0] code_in,
    output logic [LUMA_W-1:0]          luma,
    output logic [CHROMA_W-1:0]        chroma_sel,
    output logic                       show
);

    logic [LUMA_W+CHROMA_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            show   <= 1'b0;
        end else begin
            if (load)
                code_q <= code_in;
            show <= show_next;
        end
    end

    always_comb begin
        luma       = show ? code_q[LUMA_W+CHROMA_W-1:CHROMA_W] : '0;
        chroma_sel = show ? code_q[CHROMA_W-1:0] : '0;
    end

endmodule

// File: rtl/cv_chroma_phase.sv
module cv_chroma_phase #(
    parameter int PH_BITS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PH_BITS-1:0] sel,
    output logic               wave
);

    logic [PH_BITS-1:0] phase;
    logic [PH_BITS-1:0] delayed;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    always_comb begin
        delayed = phase - sel;
        wave    = (sel != '0) && !delayed[PH_BITS-1];
    end

endmodule

// File: rtl/composite_timing_gen.sv
module composite_timing_gen
    import cvgen_pkg::*;
#(
    parameter int LINE_CLKS    = 3640,
    parameter int HSYNC_CLKS   = 269,
    parameter int GAP_CLKS     = 38,
    parameter int BURST_CLKS   = 144,
    parameter int BACK_CLKS    = 89,
    parameter int ACTIVE_CLKS  = 2960,
    parameter int PIX_DIV      = 4,
    parameter int LINES        = 525,
    parameter int VSYNC_LINES  = 3,
    parameter int VBLANK_LINES = 20,
    parameter int LUMA_W       = 4,
    parameter int PH_BITS      = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LUMA_W+PH_BITS-1:0] color_code,
    output logic                      pix_req,
    output logic [LUMA_W-1:0]         luma,
    output logic                      chroma,
    output logic                      csync_n,
    output logic                      burst_en
);

    localparam int HW = $clog2(LINE_CLKS);

    logic [HW-1:0]      hcnt;
    logic               line_end, in_hsync, in_burst, in_active, pix_slot;
    vphase_e            vphase;
    logic [PH_BITS-1:0] chroma_sel;
    logic               show, in_vsync, picture;

    cv_line_fsm #(
        .LINE_CLKS(LINE_CLKS), .HSYNC_CLKS(HSYNC_CLKS), .GAP_CLKS(GAP_CLKS),
        .BURST_CLKS(BURST_CLKS), .BACK_CLKS(BACK_CLKS),
        .ACTIVE_CLKS(ACTIVE_CLKS), .PIX_DIV(PIX_DIV), .HW(HW)
    ) u_line (
        .clk(clk), .rst(rst), .hcnt(hcnt), .line_end(line_end),
        .in_hsync(in_hsync), .in_burst(in_burst), .in_active(in_active),
        .pix_slot(pix_slot)
    );

    cv_field_seq #(
        .LINE_CLKS(LINE_CLKS), .LINES(LINES), .VSYNC_LINES(VSYNC_LINES),
        .VBLANK_LINES(VBLANK_LINES), .HW(HW)
    ) u_field (
        .clk(clk), .rst(rst), .line_end(line_end), .hcnt(hcnt),
        .vphase(vphase)
    );

    cv_pixel_latch #(
        .LUMA_W(LUMA_W), .CHROMA_W(PH_BITS)
    ) u_pix (
        .clk(clk), .rst(rst), .load(pix_req),
        .show_next(in_active && picture), .code_in(color_code),
        .luma(luma), .chroma_sel(chroma_sel), .show(show)
    );

    cv_chroma_phase #(
        .PH_BITS(PH_BITS)
    ) u_phase (
        .clk(clk), .rst(rst), .sel(chroma_sel), .wave(chroma)
    );

    always_comb begin
        in_vsync = (vphase == V_SYNC);
        picture  = (vphase == V_PICTURE);
        csync_n  = !(in_hsync || in_vsync);
        burst_en = in_burst && !in_vsync;
        pix_req  = pix_slot && picture;
    end

endmodule

// File: rtl/cvgen_checker.sv
module cvgen_checker #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] color_code,
    input logic          pix_req,
    input logic [3:0]    luma,
    input logic          chroma,
    input logic          csync_n,
    input logic          burst_en
);

    AST_BURST_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (rst)
        burst_en |-> csync_n); // R3

    AST_REQ_SPACING: assert property (@(posedge clk) disable iff (rst)
        pix_req |=> !pix_req); // R4

    AST_REQ_NOT_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
        pix_req |-> (csync_n && !burst_en)); // R10

    AST_SYNC_NO_PICTURE: assert property (@(posedge clk) disable iff (rst)
        !csync_n |-> (luma == 4'd0 && !chroma)); // R10

    AST_SYNC_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(csync_n) |=> !csync_n); // R2

    AST_GREY_NO_WAVE: assert property (@(posedge clk) disable iff (rst)
        (pix_req && color_code[3:0] == 4'd0) |=> !chroma); // R6

    AST_LUMA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(pix_req) && $past(luma) != 4'd0 && luma != 4'd0) |-> $stable(luma)); // R5

endmodule

bind composite_timing_gen cvgen_checker #(.CW(LUMA_W+PH_BITS)) u_chk (
    .clk(clk), .rst(rst), .color_code(color_code), .pix_req(pix_req),
    .luma(luma), .chroma(chroma), .csync_n(csync_n), .burst_en(burst_en)
);

// File: tb/tb_composite_timing_gen.sv
module tb_composite_timing_gen;

    localparam int LINE = 160, HS = 12, GAP = 4, BUR = 16, BACK = 8, ACT = 112;
    localparam int PD = 4, LINES = 11, VS = 2, VB = 3;
    localparam int AS = HS + GAP + BUR + BACK;
    localparam int AE = AS + ACT;
    localparam int MID = (LINES - 1) / 2;
    localparam int FRAME = LINE * LINES;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] color_in = 8'd0;
    logic       pix_req, chroma, csync_n, burst_en;
    logic [3:0] luma;

    int unsigned n = 0;
    int checks = 0, errors = 0;
    bit done = 1'b0;
    bit src_fixed = 1'b0;
    logic [7:0] src_val = 8'd0;
    logic [7:0] exp_code = 8'd0;
    bit e_sync, e_burst, e_req, e_chroma;
    int e_luma;

    composite_timing_gen #(
        .LINE_CLKS(LINE), .HSYNC_CLKS(HS), .GAP_CLKS(GAP), .BURST_CLKS(BUR),
        .BACK_CLKS(BACK), .ACTIVE_CLKS(ACT), .PIX_DIV(PD), .LINES(LINES),
        .VSYNC_LINES(VS), .VBLANK_LINES(VB)
    ) dut (
        .clk(clk), .rst(rst), .color_code(color_in), .pix_req(pix_req),
        .luma(luma), .chroma(chroma), .csync_n(csync_n), .burst_en(burst_en)
    );

    always #5 clk = ~clk;

    always @(posedge clk) n <= rst ? 0 : n + 1;

    function automatic int hp(int unsigned t); return int'(t % LINE); endfunction
    function automatic int lp(int unsigned t); return int'((t / LINE) % LINES); endfunction
    function automatic bit vs_at(int unsigned t);
        int h = hp(t), l = lp(t);
        return (l < VS) || (l == MID && h >= LINE/2) || (l > MID && l < MID + VS)
            || (l == MID + VS && h < LINE/2);
    endfunction
    function automatic bit pic(int l);
        return (l >= VB && l < MID) || (l > MID + VB);
    endfunction
    function automatic bit in_act(int unsigned t);
        return hp(t) >= AS && hp(t) < AE && pic(lp(t));
    endfunction

    // reference model and pixel source
    initial begin
        forever begin
            @(negedge clk);
            e_sync  = !(hp(n) < HS || vs_at(n));
            e_burst = hp(n) >= HS + GAP && hp(n) < HS + GAP + BUR && !vs_at(n);
            e_req   = in_act(n) && ((hp(n) - AS) % PD == 0);
            if (n >= 1 && in_act(n - 1)) begin
                e_luma   = int'(exp_code[7:4]);
                e_chroma = exp_code[3:0] != 4'd0
                        && ((((n % 16) - exp_code[3:0]) & 15) < 8);
            end else begin
                e_luma   = 0;
                e_chroma = 1'b0;
            end
            color_in = src_fixed ? src_val : 8'(n * 29 + (n >> 5));
            if (rst) exp_code = 8'd0;
            else if (e_req) exp_code = color_in;
        end
    end

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at tick %0d", tag, what, act, exp, n);
        end
    endtask

    task automatic wait_n(int unsigned x);
        while (n < x) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        cmp("R1", "csync_n in reset", int'(csync_n), 0);
        rst = 1'b0;
        #1;
        cmp("R1", "csync_n", int'(csync_n), 0);
        cmp("R1", "burst_en", int'(burst_en), 0);
        cmp("R1", "pix_req", int'(pix_req), 0);
        cmp("R1", "luma", int'(luma), 0);
        cmp("R1", "chroma", int'(chroma), 0);
    endtask

    task automatic t_field1_vsync();
        for (int i = 0; i < 3 * LINE; i++) begin
            wait_n(i);
            cmp(lp(n) < VS ? "R8" : "R2", "csync_n", int'(csync_n), int'(e_sync));
            cmp("R10", "pix_req", int'(pix_req), 0);
            cmp("R10", "luma", int'(luma), 0);
            cmp("R3", "burst_en", int'(burst_en), int'(e_burst));
        end
    endtask

    task automatic t_line_timing();
        int reqs = 0;
        for (int i = 3 * LINE; i < 5 * LINE; i++) begin
            wait_n(i);
            cmp("R2", "csync_n", int'(csync_n), int'(e_sync));
            cmp("R3", "burst_en", int'(burst_en), int'(e_burst));
            cmp("R4", "pix_req", int'(pix_req), int'(e_req));
            cmp("R5", "luma", int'(luma), e_luma);
            cmp("R7", "chroma", int'(chroma), int'(e_chroma));
            if (lp(n) == 3 && pix_req) reqs++;
        end
        cmp("R4", "requests per line", reqs, ACT / PD);
    endtask

    task automatic t_field2();
        for (int i = 5 * LINE; i < 9 * LINE; i++) begin
            wait_n(i);
            cmp(vs_at(n) || lp(n) == MID + VS ? "R9" : "R2", "csync_n", int'(csync_n), int'(e_sync));
            cmp("R3", "burst_en", int'(burst_en), int'(e_burst));
            cmp("R10", "pix_req", int'(pix_req), 0);
            cmp("R10", "luma", int'(luma), 0);
            cmp("R10", "chroma", int'(chroma), 0);
        end
    endtask

    task automatic t_grey();
        src_fixed = 1'b1;
        src_val = 8'hA0;
        for (int i = 9 * LINE; i < 10 * LINE; i++) begin
            wait_n(i);
            cmp("R5", "grey luma", int'(luma), e_luma);
            cmp("R6", "grey chroma", int'(chroma), 0);
        end
    endtask

    task automatic t_black();
        src_val = 8'h00;
        for (int i = 10 * LINE; i < 11 * LINE; i++) begin
            wait_n(i);
            if (hp(n) > AS && hp(n) <= AE)
                cmp("R11", "csync_n on black", int'(csync_n), 1);
            cmp("R11", "black luma", int'(luma), 0);
            cmp("R6", "black chroma", int'(chroma), 0);
        end
        src_fixed = 1'b0;
    endtask

    task automatic t_repeat();
        for (int i = FRAME; i < FRAME + 5 * LINE; i++) begin
            wait_n(i);
            cmp("R12", "csync_n", int'(csync_n), int'(e_sync));
            cmp("R12", "burst_en", int'(burst_en), int'(e_burst));
            cmp("R12", "pix_req", int'(pix_req), int'(e_req));
            cmp("R12", "luma", int'(luma), e_luma);
            cmp("R12", "chroma", int'(chroma), int'(e_chroma));
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_field1_vsync();
        t_line_timing();
        t_field2();
        t_grey();
        t_black();
        t_repeat();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule